// File: doc/BRIEF.md
# 8x8 Bit-Matrix Multiply Unit

This combinational unit reads each 64-bit operand as a square bit matrix of eight rows and eight columns. Each byte of an operand is one row. A 2-bit select picks one of four results. The first is the transpose of the first operand. The second is the product of the two matrices over GF(2), where each result bit is the parity of a row-by-column AND. The third is the Boolean product, where each result bit is the OR of the same AND terms. The fourth code is reserved.

The unit has no clock and no storage. An execution pipeline places it between operand read and result write, and the pipeline supplies any registers it needs. Inside the unit, the second operand is transposed, so every column of it becomes a contiguous byte. Each result bit is then one 8-bit AND followed by a reduction.

Top module: `bitmat8_unit`

## Requirements
- R1: Row r of an operand occupies bits [8r+7:8r]. Within that byte, bit c (LSB first) is column c, so matrix element (r,c) is operand bit 8r+c.
- R2: With `op_sel` = 0, `result` bit 8c+r equals `op_a` bit 8r+c for all r and c in 0..7.
- R3: With `op_sel` = 0, the value on `op_b` has no effect on `result`.
- R4: With `op_sel` = 1, `result` bit 8r+c is the XOR over k of (`op_a` bit 8r+k AND `op_b` bit 8k+c).
- R5: With `op_sel` = 2, `result` bit 8r+c is the OR over k of (`op_a` bit 8r+k AND `op_b` bit 8k+c).
- R6: With `op_sel` = 3, `result` is all zeros whatever the operands.
- R7: When either operand is the identity matrix 0x8040201008040201 and `op_sel` is 1 or 2, `result` equals the other operand.
- R8: When either operand is zero and `op_sel` is 1 or 2, `result` is zero.
- R9: `result` is purely combinational. It follows any change on the inputs without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 64 | First matrix, one row per byte |
| op_b | input | 64 | Second matrix, one row per byte |
| op_sel | input | 2 | 0 transpose, 1 XOR product, 2 OR product, 3 reserved |
| result | output | 64 | Selected result matrix |

## Verification
The bench places a single set bit at a known row and column. A design that swapped the row and column index order would move that bit to the wrong position instead of its mirror position. Random operands are compared against a nested-loop model under both products. This catches a parity reduction confused with an OR, and a product that skipped transposing the second operand. Identity and zero operands are driven on either side, and the reserved code and the unused second operand of the transpose are exercised. A design that leaked `op_b` into the transpose, or returned a product for code 3, would show a changed result.

// File: rtl/bitmat8_unit.sv
module bitmat8_unit #(
  parameter int DIM = 8
) (
  input  logic [DIM*DIM-1:0] op_a,
  input  logic [DIM*DIM-1:0] op_b,
  input  logic [1:0]         op_sel,
  output logic [DIM*DIM-1:0] result
);
  localparam int W = DIM * DIM;

  logic [W-1:0] a_tr;
  logic [W-1:0] b_tr;
  logic [W-1:0] prod_x;
  logic [W-1:0] prod_o;

  for (genvar r = 0; r < DIM; r++) begin : g_row
    for (genvar c = 0; c < DIM; c++) begin : g_col
      logic [DIM-1:0] hit;
      assign a_tr[c*DIM + r] = op_a[r*DIM + c];
      assign b_tr[c*DIM + r] = op_b[r*DIM + c];
      assign hit             = op_a[r*DIM +: DIM] & b_tr[c*DIM +: DIM];
      assign prod_x[r*DIM + c] = ^hit;
      assign prod_o[r*DIM + c] = |hit;
    end
  end

  always_comb begin
    case (op_sel)
      2'd0:    result = a_tr;
      2'd1:    result = prod_x;
      2'd2:    result = prod_o;
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/bitmat8_unit_chk.sv
module bitmat8_unit_chk #(
  parameter int DIM = 8
) (
  input logic [DIM*DIM-1:0] op_a,
  input logic [DIM*DIM-1:0] op_b,
  input logic [1:0]         op_sel,
  input logic [DIM*DIM-1:0] result
);
  localparam int W = DIM * DIM;

  function automatic logic [W-1:0] unit_mat();
    logic [W-1:0] m;
    m = '0;
    for (int k = 0; k < DIM; k++) m[k*DIM + k] = 1'b1;
    return m;
  endfunction

  localparam logic [W-1:0] IDENT = unit_mat();

  logic is_prod;
  assign is_prod = (op_sel == 2'd1) || (op_sel == 2'd2);

  always_comb begin
    // R6
    reserved_zero_chk: assert (op_sel != 2'd3 || result == '0);
    // R2
    flip_count_chk: assert (op_sel != 2'd0 || $countones(result) == $countones(op_a));
    // R2
    flip_diag_chk: assert (op_sel != 2'd0 || (result & IDENT) == (op_a & IDENT));
    // R7
    ident_right_chk: assert (!(is_prod && op_b == IDENT) || result == op_a);
    // R7
    ident_left_chk: assert (!(is_prod && op_a == IDENT) || result == op_b);
    // R8
    zero_opnd_chk: assert (!(is_prod && (op_a == '0 || op_b == '0)) || result == '0);
  end
endmodule

bind bitmat8_unit bitmat8_unit_chk #(.DIM(DIM)) u_chk (
  .op_a(op_a), .op_b(op_b), .op_sel(op_sel), .result(result)
);

// File: tb/bitmat8_unit_test.sv
`timescale 1ns/1ps
module bitmat8_unit_test;
  localparam logic [63:0] IDENT = 64'h8040201008040201;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic [1:0]  op_sel = '0;
  logic [63:0] result;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bitmat8_unit uut (.op_a(op_a), .op_b(op_b), .op_sel(op_sel), .result(result));

  function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b, logic [1:0] s);
    logic [63:0] m;
    m = '0;
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) begin
        logic x;
        logic o;
        x = 1'b0;
        o = 1'b0;
        for (int k = 0; k < 8; k++) begin
          x = x ^ (a[8*r+k] & b[8*k+c]);
          o = o | (a[8*r+k] & b[8*k+c]);
        end
        case (s)
          2'd0: m[8*c+r] = a[8*r+c];
          2'd1: m[8*r+c] = x;
          2'd2: m[8*r+c] = o;
          default: m[8*r+c] = 1'b0;
        endcase
      end
    return m;
  endfunction

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic apply(logic [63:0] a, logic [63:0] b, logic [1:0] s);
    @(negedge clk);
    op_a = a;
    op_b = b;
    op_sel = s;
    #1;
  endtask

  task automatic t_idle();
    apply('0, '0, 2'd0);
    chk("R2 idle", result, 64'h0);
  endtask

  task automatic t_layout();
    // R1: element (2,5) is bit 21; its transpose lands on bit 42
    apply(64'h1 << 21, '0, 2'd0);
    chk("R1 layout", result, 64'h1 << 42);
    apply(64'h0123456789abcdef, '0, 2'd0);
    chk("R2 flip", result, model(64'h0123456789abcdef, '0, 2'd0));
  endtask

  task automatic t_flip_ignore_b();
    logic [63:0] first;
    apply(64'hdeadbeef00c0ffee, 64'h0, 2'd0);
    first = result;
    apply(64'hdeadbeef00c0ffee, 64'hffffffffffffffff, 2'd0);
    chk("R3 b ignored", result, first);
    apply(64'hdeadbeef00c0ffee, 64'h5a5a5a5a12345678, 2'd0);
    chk("R3 b ignored", result, first);
  endtask

  task automatic t_products(logic [1:0] s, string req);
    for (int n = 0; n < 40; n++) begin
      logic [63:0] a;
      logic [63:0] b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      apply(a, b, s);
      chk(req, result, model(a, b, s));
    end
  endtask

  task automatic t_reserved();
    apply(64'hffffffffffffffff, 64'hffffffffffffffff, 2'd3);
    chk("R6 reserved", result, 64'h0);
    apply(IDENT, IDENT, 2'd3);
    chk("R6 reserved", result, 64'h0);
  endtask

  task automatic t_identity();
    apply(64'h13579bdf2468ace0, IDENT, 2'd1);
    chk("R7 ident xor", result, 64'h13579bdf2468ace0);
    apply(64'h13579bdf2468ace0, IDENT, 2'd2);
    chk("R7 ident or", result, 64'h13579bdf2468ace0);
    apply(IDENT, 64'hfedcba9876543210, 2'd1);
    chk("R7 ident left", result, 64'hfedcba9876543210);
  endtask

  task automatic t_zero();
    apply(64'hffffffffffffffff, '0, 2'd1);
    chk("R8 zero b", result, 64'h0);
    apply('0, 64'hffffffffffffffff, 2'd2);
    chk("R8 zero a", result, 64'h0);
    // all ones: eight terms per bit, even parity, OR set
    apply(64'hffffffffffffffff, 64'hffffffffffffffff, 2'd1);
    chk("R4 all ones", result, 64'h0);
    apply(64'hffffffffffffffff, 64'hffffffffffffffff, 2'd2);
    chk("R5 all ones", result, 64'hffffffffffffffff);
  endtask

  task automatic t_comb();
    @(posedge clk);
    #1;
    op_a = 64'h00000000000000ff;
    op_b = 64'h0101010101010101;
    op_sel = 2'd2;
    #1;
    chk("R9 no clock", result, model(64'h00000000000000ff, 64'h0101010101010101, 2'd2));
    op_sel = 2'd1;
    #1;
    chk("R9 no clock", result, model(64'h00000000000000ff, 64'h0101010101010101, 2'd1));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_idle();
    t_layout();
    t_flip_ignore_b();
    t_products(2'd1, "R4 xor prod");
    t_products(2'd2, "R5 or prod");
    t_reserved();
    t_identity();
    t_zero();
    t_comb();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule